// File: doc/BRIEF.md
# Zoned Interlock Voter with Controlled Bypass

This block watches a set of guarded zones (doors, modules, covers). Each zone reports two redundant open/closed channels and three line-fault flags. The block votes the two channels per zone, either as "any channel open trips" or as "both channels open trips", according to a per-zone select. It classifies line faults into distinct codes, publishes a registered per-zone trip bitmap and fault code, and drives one combined trip output. An emergency-stop input always reaches the combined trip.

A maintenance bypass can hide the trips of a chosen set of zones. The bypass can start only in service mode and only with a valid token. It runs on a time-to-live counter, publishes a derating profile while it is active, and collapses into a latched safe stop when an over-current or over-temperature excursion is reported. It can also collapse into that safe stop on expiry if configured to. Every bypass transition emits a one-cycle event code.

Top module: `zone_interlock_voter`

## Requirements
- R1: With vote select 0 for a zone, the zone's trip bit and the combined trip are set one cycle after either channel reports open. The zone fault code is then 5 (vote trip). Zone i's code occupies bits [3i+2:3i] of the fault-code output.
- R2: With vote select 1, one open channel alone does not trip the zone. After the channels disagree on DISAGREE_LIMIT consecutive clock edges, the zone's channel-fault bit is set and its code is 4. When both channels are open, the zone trips with code 5, and the channel fault clears once the channels agree.
- R3: A line-open flag trips the zone one cycle later, with fault code 1.
- R4: A short to ground trips the zone with code 2, and a short to supply trips it with code 3. Short-to-ground outranks short-to-supply, which outranks open wire, then channel fault, then vote trip.
- R5: The emergency-stop input sets the combined trip one cycle later, with or without bypass and regardless of the scope mask.
- R6: A bypass request enters bypass only when service mode and token valid are both high. Entry emits event code 1 and drives the latched derating profile with derating enable high. Otherwise there is no event and bypass stays off.
- R7: During bypass, zones selected in the scope mask latched at entry do not reach the combined trip, but their per-zone trip bits are still reported. Unselected zones still trip.
- R8: A renew request with a valid token reloads the TTL from the load value and emits event code 2. Without a token it is ignored: no event, and the counter is not reloaded.
- R9: Bypass lasts the loaded TTL plus one cycle, then expires with event code 4. With the expiry-to-stop bit clear it returns to idle. With the bit set it enters safe stop, which forces the combined trip until a confirm pulse.
- R10: A cancel request, or service mode dropping, ends bypass on the next edge with event code 3.
- R11: An over-current or over-temperature report during bypass sets the combined trip on the next edge and enters safe stop with event code 5. Outside bypass these inputs have no effect.
- R12: After reset, all trips, bypass, safe stop, derating and events are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chanAOpen | input | NUM_ZONES | Channel A reports open, per zone |
| chanBOpen | input | NUM_ZONES | Channel B reports open, per zone |
| voteSel | input | NUM_ZONES | 0 = any channel trips, 1 = both channels needed |
| lineOpen | input | NUM_ZONES | Open-wire flag per zone |
| lineShortGnd | input | NUM_ZONES | Short-to-ground flag per zone |
| lineShortVcc | input | NUM_ZONES | Short-to-supply flag per zone |
| estop | input | 1 | Unmaskable hard trip |
| overCurrent | input | 1 | Over-current excursion report |
| overTemp | input | 1 | Over-temperature excursion report |
| serviceMode | input | 1 | High when the system is in service mode |
| tokenValid | input | 1 | Bypass authorization present |
| bypassReq | input | 1 | Request to enter bypass |
| renewReq | input | 1 | Request to reload the TTL |
| cancelReq | input | 1 | Request to leave bypass |
| confirmAck | input | 1 | Operator confirmation that releases safe stop |
| expiryToStop | input | 1 | 1 = expiry enters safe stop, 0 = expiry returns to idle |
| ttlLoad | input | TTL_W | TTL value loaded on entry or renewal |
| scopeMask | input | NUM_ZONES | Zones the bypass may hide, latched on entry |
| profileSel | input | PROFILE_W | Derating profile latched on entry |
| zoneTrip | output | NUM_ZONES | Registered per-zone trip bitmap |
| chanFault | output | NUM_ZONES | Sustained channel disagreement per zone |
| zoneFaultCode | output | 3*NUM_ZONES | Per-zone fault code, 3 bits per zone |
| tripOut | output | 1 | Combined trip |
| bypassActive | output | 1 | Bypass in force |
| safeStop | output | 1 | Latched safe stop awaiting confirmation |
| deratingEn | output | 1 | Derating must be applied |
| deratingOut | output | PROFILE_W | Active derating profile, zero when inactive |
| eventValid | output | 1 | One-cycle bypass event strobe |
| eventCode | output | 3 | 1 enable, 2 renew, 3 cancel, 4 expire, 5 excursion abort |

## Verification
The bench goes after the TTL boundary. It checks that bypass is still active in the last counted cycle and gone one cycle later, so an off-by-one counter would end bypass early or hold it too long. It checks that a masked zone keeps its per-zone trip bit while the combined trip stays low, and that an emergency stop or an unmasked zone still trips during bypass; a design that masked the wrong vector would either hide the emergency stop or trip through the bypass. It drives simultaneous line faults to expose a wrong priority order, and it holds a 2oo2 disagreement for exactly the limit to catch a fault flag that is early or late. It also covers renewals without a token, a drop out of service mode and excursions both inside and outside bypass, where a careless design would extend the bypass, keep it alive or trip on a harmless report.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

  typedef enum logic [2:0] {
    FC_NONE      = 3'd0,
    FC_OPEN      = 3'd1,
    FC_SHORT_GND = 3'd2,
    FC_SHORT_VCC = 3'd3,
    FC_CHAN      = 3'd4,
    FC_VOTE      = 3'd5
  } faultCode_e;

  typedef enum logic [2:0] {
    EV_NONE   = 3'd0,
    EV_ENABLE = 3'd1,
    EV_RENEW  = 3'd2,
    EV_CANCEL = 3'd3,
    EV_EXPIRE = 3'd4,
    EV_ABORT  = 3'd5
  } bypassEvent_e;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_BYPASS   = 2'd1,
    ST_SAFESTOP = 2'd2
  } bypassState_e;

  // Strobes from the bypass control to the zone datapath
  typedef struct packed {
    logic bypassOn;
    logic safeStop;
    logic excursionHit;
  } ctlStrobe_t;

  // Highest-ranked condition wins: wiring faults, then channel fault, then vote
  function automatic faultCode_e classify(input logic gnd, input logic vcc,
                                          input logic open, input logic chan,
                                          input logic vote);
    if (gnd)       return FC_SHORT_GND;
    else if (vcc)  return FC_SHORT_VCC;
    else if (open) return FC_OPEN;
    else if (chan) return FC_CHAN;
    else if (vote) return FC_VOTE;
    else           return FC_NONE;
  endfunction

endpackage

// File: rtl/ilk_zone_path.sv
module ilk_zone_path
  import ilk_pkg::*;
#(
  parameter int NUM_ZONES      = 4,
  parameter int DISAGREE_LIMIT = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_ZONES-1:0]   chanAOpen,
  input  logic [NUM_ZONES-1:0]   chanBOpen,
  input  logic [NUM_ZONES-1:0]   voteSel,
  input  logic [NUM_ZONES-1:0]   lineOpen,
  input  logic [NUM_ZONES-1:0]   lineShortGnd,
  input  logic [NUM_ZONES-1:0]   lineShortVcc,
  input  logic                   estop,
  input  ctlStrobe_t             ctl,
  input  logic [NUM_ZONES-1:0]   maskSel,
  output logic [NUM_ZONES-1:0]   zoneTrip,
  output logic [NUM_ZONES-1:0]   chanFault,
  output logic [3*NUM_ZONES-1:0] zoneFaultCode,
  output logic                   tripOut
);

  localparam int CNT_W = $clog2(DISAGREE_LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DISAGREE_LIMIT);

  logic [NUM_ZONES-1:0]   rawTripD;
  logic [NUM_ZONES-1:0]   chanHitD;
  logic [3*NUM_ZONES-1:0] codeD;
  logic [NUM_ZONES-1:0]   effMask;
  logic                   tripD;

  for (genvar z = 0; z < NUM_ZONES; z++) begin : g_zone
    logic [CNT_W-1:0] disCntQ;
    logic [CNT_W-1:0] disCntD;
    logic             voteHit;
    faultCode_e       zoneCode;

    always_comb begin
      if (chanAOpen[z] != chanBOpen[z])
        disCntD = (disCntQ == CNT_MAX) ? disCntQ : disCntQ + 1'b1;
      else
        disCntD = '0;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) disCntQ <= '0;
      else       disCntQ <= disCntD;
    end

    assign voteHit     = voteSel[z] ? (chanAOpen[z] & chanBOpen[z])
                                    : (chanAOpen[z] | chanBOpen[z]);
    assign chanHitD[z] = (disCntD == CNT_MAX);
    assign rawTripD[z] = lineOpen[z] | lineShortGnd[z] | lineShortVcc[z] | voteHit;
    assign zoneCode    = classify(lineShortGnd[z], lineShortVcc[z], lineOpen[z],
                                  chanHitD[z], voteHit);
    assign codeD[3*z +: 3] = zoneCode;

    // R1: either open channel trips a zone in 1oo2
    a_r1_single_chan_trips: assert property (@(posedge clk) disable iff (!rstN)
      (!voteSel[z] && (chanAOpen[z] || chanBOpen[z])) |=> zoneTrip[z]);
    // R2: one open channel alone does not trip a healthy 2oo2 zone
    a_r2_single_chan_holds: assert property (@(posedge clk) disable iff (!rstN)
      (voteSel[z] && (chanAOpen[z] != chanBOpen[z]) && !lineOpen[z]
       && !lineShortGnd[z] && !lineShortVcc[z]) |=> !zoneTrip[z]);
    // R3: open wire trips with a non-zero code
    a_r3_open_wire_coded: assert property (@(posedge clk) disable iff (!rstN)
      lineOpen[z] |=> (zoneTrip[z] && zoneFaultCode[3*z +: 3] != 3'd0));
  end

  assign effMask = ctl.bypassOn ? maskSel : '0;
  assign tripD   = estop | ctl.safeStop | ctl.excursionHit | (|(rawTripD & ~effMask));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      zoneTrip      <= '0;
      chanFault     <= '0;
      zoneFaultCode <= '0;
      tripOut       <= 1'b0;
    end else begin
      zoneTrip      <= rawTripD;
      chanFault     <= chanHitD;
      zoneFaultCode <= codeD;
      tripOut       <= tripD;
    end
  end

  // R5: emergency stop is never masked
  a_r5_estop_trips: assert property (@(posedge clk) disable iff (!rstN)
    estop |=> tripOut);
  // R9: safe stop forces the combined trip
  a_r9_safestop_trips: assert property (@(posedge clk) disable iff (!rstN)
    ctl.safeStop |=> tripOut);

endmodule

// File: rtl/ilk_bypass_ctrl.sv
module ilk_bypass_ctrl
  import ilk_pkg::*;
#(
  parameter int NUM_ZONES = 4,
  parameter int TTL_W     = 8,
  parameter int PROFILE_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 serviceMode,
  input  logic                 tokenValid,
  input  logic                 bypassReq,
  input  logic                 renewReq,
  input  logic                 cancelReq,
  input  logic                 confirmAck,
  input  logic                 overCurrent,
  input  logic                 overTemp,
  input  logic                 expiryToStop,
  input  logic [TTL_W-1:0]     ttlLoad,
  input  logic [NUM_ZONES-1:0] scopeMask,
  input  logic [PROFILE_W-1:0] profileSel,
  output ctlStrobe_t           ctl,
  output logic [NUM_ZONES-1:0] maskSel,
  output logic                 bypassActive,
  output logic                 safeStop,
  output logic                 deratingEn,
  output logic [PROFILE_W-1:0] deratingOut,
  output logic                 eventValid,
  output logic [2:0]           eventCode
);

  bypassState_e         stQ, stD;
  logic [TTL_W-1:0]     ttlQ, ttlD;
  logic [NUM_ZONES-1:0] maskQ, maskD;
  logic [PROFILE_W-1:0] profQ, profD;
  bypassEvent_e         evD;
  logic                 excursion;

  assign excursion = overCurrent | overTemp;

  always_comb begin
    stD   = stQ;
    ttlD  = ttlQ;
    maskD = maskQ;
    profD = profQ;
    evD   = EV_NONE;
    unique case (stQ)
      ST_IDLE: begin
        if (bypassReq && serviceMode && tokenValid) begin
          stD   = ST_BYPASS;
          ttlD  = ttlLoad;
          maskD = scopeMask;
          profD = profileSel;
          evD   = EV_ENABLE;
        end
      end
      ST_BYPASS: begin
        if (excursion) begin
          stD = ST_SAFESTOP;
          evD = EV_ABORT;
        end else if (!serviceMode || cancelReq) begin
          stD = ST_IDLE;
          evD = EV_CANCEL;
        end else if (renewReq && tokenValid) begin
          ttlD = ttlLoad;
          evD  = EV_RENEW;
        end else if (ttlQ == '0) begin
          stD = expiryToStop ? ST_SAFESTOP : ST_IDLE;
          evD = EV_EXPIRE;
        end else begin
          ttlD = ttlQ - 1'b1;
        end
      end
      ST_SAFESTOP: begin
        if (confirmAck) stD = ST_IDLE;
      end
      default: stD = ST_SAFESTOP;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ        <= ST_IDLE;
      ttlQ       <= '0;
      maskQ      <= '0;
      profQ      <= '0;
      eventValid <= 1'b0;
      eventCode  <= 3'd0;
    end else begin
      stQ        <= stD;
      ttlQ       <= ttlD;
      maskQ      <= maskD;
      profQ      <= profD;
      eventValid <= (evD != EV_NONE);
      eventCode  <= evD;
    end
  end

  assign bypassActive     = (stQ == ST_BYPASS);
  assign safeStop         = (stQ == ST_SAFESTOP);
  assign deratingEn       = bypassActive;
  assign deratingOut      = bypassActive ? profQ : '0;
  assign maskSel          = maskQ;
  assign ctl.bypassOn     = bypassActive;
  assign ctl.safeStop     = safeStop;
  assign ctl.excursionHit = bypassActive & excursion;

  // R6: entry only with service mode and token, and it is announced
  a_r6_entry_gated: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bypassActive) |-> $past(serviceMode && tokenValid));
  a_r6_entry_event: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bypassActive) |-> (eventValid && eventCode == 3'd1));
  // R10: leaving service mode ends bypass at once
  a_r10_mode_exit: assert property (@(posedge clk) disable iff (!rstN)
    (bypassActive && !serviceMode) |=> !bypassActive);
  // R11: an excursion during bypass lands in safe stop
  a_r11_excursion_stop: assert property (@(posedge clk) disable iff (!rstN)
    (bypassActive && (overCurrent || overTemp)) |=> (safeStop && !bypassActive));

endmodule

// File: rtl/zone_interlock_voter.sv
module zone_interlock_voter
  import ilk_pkg::*;
#(
  parameter int NUM_ZONES      = 4,
  parameter int TTL_W          = 8,
  parameter int PROFILE_W      = 4,
  parameter int DISAGREE_LIMIT = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_ZONES-1:0]   chanAOpen,
  input  logic [NUM_ZONES-1:0]   chanBOpen,
  input  logic [NUM_ZONES-1:0]   voteSel,
  input  logic [NUM_ZONES-1:0]   lineOpen,
  input  logic [NUM_ZONES-1:0]   lineShortGnd,
  input  logic [NUM_ZONES-1:0]   lineShortVcc,
  input  logic                   estop,
  input  logic                   overCurrent,
  input  logic                   overTemp,
  input  logic                   serviceMode,
  input  logic                   tokenValid,
  input  logic                   bypassReq,
  input  logic                   renewReq,
  input  logic                   cancelReq,
  input  logic                   confirmAck,
  input  logic                   expiryToStop,
  input  logic [TTL_W-1:0]       ttlLoad,
  input  logic [NUM_ZONES-1:0]   scopeMask,
  input  logic [PROFILE_W-1:0]   profileSel,
  output logic [NUM_ZONES-1:0]   zoneTrip,
  output logic [NUM_ZONES-1:0]   chanFault,
  output logic [3*NUM_ZONES-1:0] zoneFaultCode,
  output logic                   tripOut,
  output logic                   bypassActive,
  output logic                   safeStop,
  output logic                   deratingEn,
  output logic [PROFILE_W-1:0]   deratingOut,
  output logic                   eventValid,
  output logic [2:0]             eventCode
);

  ctlStrobe_t           ctl;
  logic [NUM_ZONES-1:0] maskSel;

  ilk_bypass_ctrl #(
    .NUM_ZONES(NUM_ZONES), .TTL_W(TTL_W), .PROFILE_W(PROFILE_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .serviceMode(serviceMode), .tokenValid(tokenValid),
    .bypassReq(bypassReq), .renewReq(renewReq), .cancelReq(cancelReq),
    .confirmAck(confirmAck), .overCurrent(overCurrent), .overTemp(overTemp),
    .expiryToStop(expiryToStop), .ttlLoad(ttlLoad), .scopeMask(scopeMask),
    .profileSel(profileSel), .ctl(ctl), .maskSel(maskSel),
    .bypassActive(bypassActive), .safeStop(safeStop),
    .deratingEn(deratingEn), .deratingOut(deratingOut),
    .eventValid(eventValid), .eventCode(eventCode)
  );

  ilk_zone_path #(
    .NUM_ZONES(NUM_ZONES), .DISAGREE_LIMIT(DISAGREE_LIMIT)
  ) u_path (
    .clk(clk), .rstN(rstN),
    .chanAOpen(chanAOpen), .chanBOpen(chanBOpen), .voteSel(voteSel),
    .lineOpen(lineOpen), .lineShortGnd(lineShortGnd), .lineShortVcc(lineShortVcc),
    .estop(estop), .ctl(ctl), .maskSel(maskSel),
    .zoneTrip(zoneTrip), .chanFault(chanFault),
    .zoneFaultCode(zoneFaultCode), .tripOut(tripOut)
  );

endmodule

// File: tb/zone_interlock_voter_tb.sv
`timescale 1ns/1ps
module zone_interlock_voter_tb;

  localparam int NZ = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NZ-1:0] chanAOpen = '0, chanBOpen = '0, voteSel = '0;
  logic [NZ-1:0] lineOpen = '0, lineShortGnd = '0, lineShortVcc = '0;
  logic estop = 0, overCurrent = 0, overTemp = 0, serviceMode = 0, tokenValid = 0;
  logic bypassReq = 0, renewReq = 0, cancelReq = 0, confirmAck = 0, expiryToStop = 0;
  logic [7:0] ttlLoad = '0;
  logic [NZ-1:0] scopeMask = '0;
  logic [3:0] profileSel = '0;
  logic [NZ-1:0] zoneTrip, chanFault;
  logic [3*NZ-1:0] zoneFaultCode;
  logic tripOut, bypassActive, safeStop, deratingEn, eventValid;
  logic [3:0] deratingOut;
  logic [2:0] eventCode;

  always #2.5 clk = ~clk;

  zone_interlock_voter u_dut (
    .clk(clk), .rstN(rstN), .chanAOpen(chanAOpen), .chanBOpen(chanBOpen),
    .voteSel(voteSel), .lineOpen(lineOpen), .lineShortGnd(lineShortGnd),
    .lineShortVcc(lineShortVcc), .estop(estop), .overCurrent(overCurrent),
    .overTemp(overTemp), .serviceMode(serviceMode), .tokenValid(tokenValid),
    .bypassReq(bypassReq), .renewReq(renewReq), .cancelReq(cancelReq),
    .confirmAck(confirmAck), .expiryToStop(expiryToStop), .ttlLoad(ttlLoad),
    .scopeMask(scopeMask), .profileSel(profileSel), .zoneTrip(zoneTrip),
    .chanFault(chanFault), .zoneFaultCode(zoneFaultCode), .tripOut(tripOut),
    .bypassActive(bypassActive), .safeStop(safeStop), .deratingEn(deratingEn),
    .deratingOut(deratingOut), .eventValid(eventValid), .eventCode(eventCode)
  );

  localparam int S_TRIP = 0, S_ZONE = 1, S_CHF = 2, S_BYP = 3, S_SAFE = 4,
                 S_DER = 5, S_EVV = 6, S_EVC = 7, S_CODE = 8, S_DEN = 9;

  typedef struct {
    int          due;
    int          sel;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  int cyc = 0;
  int compared = 0;
  int mismatched = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] observe(int sel);
    case (sel)
      S_TRIP:  return 32'(tripOut);
      S_ZONE:  return 32'(zoneTrip);
      S_CHF:   return 32'(chanFault);
      S_BYP:   return 32'(bypassActive);
      S_SAFE:  return 32'(safeStop);
      S_DER:   return 32'(deratingOut);
      S_EVV:   return 32'(eventValid);
      S_EVC:   return 32'(eventCode);
      S_CODE:  return 32'(zoneFaultCode);
      default: return 32'(deratingEn);
    endcase
  endfunction

  // Monitor: pops every item due in this cycle and compares it
  always @(negedge clk) begin
    for (int k = sb.size() - 1; k >= 0; k--) begin
      if (sb[k].due == cyc) begin
        compared++;
        if (observe(sb[k].sel) !== sb[k].exp) begin
          mismatched++;
          $display("FAIL %s (cycle %0d, sel %0d): actual %0h expected %0h",
                   sb[k].tag, cyc, sb[k].sel, observe(sb[k].sel), sb[k].exp);
        end
        sb.delete(k);
      end
    end
  end

  task automatic expect_at(int d, int sel, logic [31:0] v, string tag);
    item_t it;
    it.due = cyc + d; it.sel = sel; it.exp = v; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    // R12: quiet after reset
    expect_at(1, S_TRIP, 0, "R12 trip"); expect_at(1, S_ZONE, 0, "R12 zones");
    expect_at(1, S_BYP, 0, "R12 bypass"); expect_at(1, S_SAFE, 0, "R12 safe");
    expect_at(1, S_EVV, 0, "R12 event"); expect_at(1, S_DER, 0, "R12 derate");
    tick(1);

    // R1: any single channel trips a 1oo2 zone
    chanAOpen[0] = 1;
    expect_at(1, S_ZONE, 1, "R1 chanA"); expect_at(1, S_TRIP, 1, "R1 trip");
    expect_at(1, S_CODE, 5, "R1 code");
    tick(1);
    chanAOpen[0] = 0; chanBOpen[0] = 1;
    expect_at(1, S_ZONE, 1, "R1 chanB");
    tick(1);
    chanBOpen[0] = 0;
    expect_at(1, S_ZONE, 0, "R1 clear"); expect_at(1, S_TRIP, 0, "R1 trip clear");
    tick(1);

    // R2: 2oo2 vote and sustained disagreement
    voteSel = 4'b0010; chanAOpen[1] = 1;
    expect_at(1, S_ZONE, 0, "R2 single open"); expect_at(1, S_TRIP, 0, "R2 no trip");
    expect_at(3, S_CHF, 0, "R2 fault early");
    expect_at(4, S_CHF, 4'b0010, "R2 fault at limit");
    expect_at(4, S_CODE, 4 << 3, "R2 chan code");
    tick(4);
    chanBOpen[1] = 1;
    expect_at(1, S_ZONE, 4'b0010, "R2 both open"); expect_at(1, S_CHF, 0, "R2 fault clears");
    expect_at(1, S_CODE, 5 << 3, "R2 vote code"); expect_at(1, S_TRIP, 1, "R2 trip");
    tick(1);
    chanAOpen[1] = 0; chanBOpen[1] = 0;
    expect_at(1, S_ZONE, 0, "R2 clear");
    tick(1);

    // R3: open wire
    lineOpen[2] = 1;
    expect_at(1, S_ZONE, 4'b0100, "R3 zone"); expect_at(1, S_CODE, 1 << 6, "R3 code");
    expect_at(1, S_TRIP, 1, "R3 trip");
    tick(1);
    lineOpen[2] = 0;
    tick(1);

    // R4: shorts and priority
    lineShortGnd[3] = 1; lineOpen[3] = 1;
    expect_at(1, S_ZONE, 4'b1000, "R4 zone"); expect_at(1, S_CODE, 2 << 9, "R4 gnd wins");
    tick(1);
    lineShortGnd[3] = 0; lineOpen[3] = 0; lineShortVcc[3] = 1;
    expect_at(1, S_CODE, 3 << 9, "R4 vcc code"); expect_at(1, S_TRIP, 1, "R4 trip");
    tick(1);
    lineShortVcc[3] = 0;
    expect_at(1, S_CODE, 0, "R4 code clear"); expect_at(1, S_TRIP, 0, "R4 trip clear");
    tick(1);

    // R5: emergency stop
    estop = 1;
    expect_at(1, S_TRIP, 1, "R5 estop"); expect_at(1, S_ZONE, 0, "R5 zones");
    tick(1);
    estop = 0;
    tick(1);

    // R6: entry gating
    bypassReq = 1; serviceMode = 0; tokenValid = 1;
    expect_at(1, S_BYP, 0, "R6 no service"); expect_at(1, S_EVV, 0, "R6 no event");
    tick(1);
    serviceMode = 1; tokenValid = 0;
    expect_at(1, S_BYP, 0, "R6 no token"); expect_at(1, S_EVV, 0, "R6 no event 2");
    tick(1);
    tokenValid = 1; ttlLoad = 40; scopeMask = 4'b0001; profileSel = 5;
    expect_at(1, S_BYP, 1, "R6 enter"); expect_at(1, S_EVV, 1, "R6 event");
    expect_at(1, S_EVC, 1, "R6 enable code"); expect_at(1, S_DER, 5, "R6 profile");
    expect_at(1, S_DEN, 1, "R6 derate en");
    tick(1);
    bypassReq = 0;
    expect_at(1, S_EVV, 0, "R6 one-shot"); expect_at(1, S_BYP, 1, "R6 stays");
    tick(1);

    // R7: masking, with estop and unmasked zone still tripping
    chanAOpen[0] = 1;
    expect_at(1, S_TRIP, 0, "R7 masked"); expect_at(1, S_ZONE, 1, "R7 still reported");
    tick(1);
    estop = 1;
    expect_at(1, S_TRIP, 1, "R5 estop in bypass");
    tick(1);
    estop = 0; chanAOpen[0] = 0; lineOpen[2] = 1;
    expect_at(1, S_TRIP, 1, "R7 unmasked zone");
    tick(1);
    lineOpen[2] = 0;
    expect_at(1, S_TRIP, 0, "R7 clear");
    tick(1);

    // R8: renew without, then with token; R9: exact TTL and expiry to idle
    tokenValid = 0; renewReq = 1;
    expect_at(1, S_EVV, 0, "R8 renew ignored"); expect_at(1, S_BYP, 1, "R8 still on");
    tick(1);
    tokenValid = 1; ttlLoad = 3;
    expect_at(1, S_EVV, 1, "R8 renew event"); expect_at(1, S_EVC, 2, "R8 renew code");
    expect_at(4, S_BYP, 1, "R9 last cycle");
    expect_at(5, S_BYP, 0, "R9 expired"); expect_at(5, S_EVC, 4, "R9 expire code");
    expect_at(5, S_EVV, 1, "R9 expire event"); expect_at(5, S_SAFE, 0, "R9 to idle");
    expect_at(5, S_DEN, 0, "R9 derate off");
    tick(1);
    renewReq = 0;
    tick(5);

    // R9: expiry into safe stop, released by confirm
    expiryToStop = 1; ttlLoad = 0; bypassReq = 1;
    expect_at(1, S_BYP, 1, "R9 enter");
    expect_at(2, S_SAFE, 1, "R9 safe stop"); expect_at(2, S_EVC, 4, "R9 expire code 2");
    expect_at(3, S_TRIP, 1, "R9 safe trip");
    tick(1);
    bypassReq = 0;
    tick(3);
    confirmAck = 1;
    expect_at(1, S_SAFE, 0, "R9 confirmed"); expect_at(2, S_TRIP, 0, "R9 trip released");
    tick(1);
    confirmAck = 0; expiryToStop = 0;
    tick(1);

    // R10: mode drop and cancel
    ttlLoad = 50; bypassReq = 1;
    tick(1);
    bypassReq = 0; serviceMode = 0;
    expect_at(1, S_BYP, 0, "R10 mode drop"); expect_at(1, S_EVC, 3, "R10 drop code");
    expect_at(1, S_EVV, 1, "R10 drop event");
    tick(1);
    serviceMode = 1; bypassReq = 1;
    tick(1);
    bypassReq = 0; cancelReq = 1;
    expect_at(1, S_BYP, 0, "R10 cancel"); expect_at(1, S_EVC, 3, "R10 cancel code");
    tick(1);
    cancelReq = 0;
    tick(1);

    // R11: excursion outside and inside bypass
    overTemp = 1;
    expect_at(1, S_TRIP, 0, "R11 idle no trip"); expect_at(1, S_SAFE, 0, "R11 idle no stop");
    tick(1);
    overTemp = 0; bypassReq = 1;
    tick(1);
    bypassReq = 0; overCurrent = 1;
    expect_at(1, S_TRIP, 1, "R11 trip"); expect_at(1, S_SAFE, 1, "R11 safe stop");
    expect_at(1, S_BYP, 0, "R11 bypass off"); expect_at(1, S_EVC, 5, "R11 abort code");
    tick(1);
    overCurrent = 0; confirmAck = 1;
    expect_at(1, S_SAFE, 0, "R11 confirmed");
    tick(1);
    confirmAck = 0;
    tick(3);

    if (sb.size() != 0) begin
      compared++;
      mismatched++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
    end
    finish_run();
  end

endmodule